// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block gathers thirty level-sensitive interrupt request lines and two non-maskable lines and presents them to a processor core. It registers every line once, then gates the maskable requests through a mask that software writes. From the gated result it drives one interrupt request wire and an 8-bit vector bus. When a single gated source is active, the vector names that source. When several are active, a shared vector tells software to resolve priority itself. The controller arbitrates nothing.

A small register port with 32-bit data lets software write the mask. Through the same port it can read back the mask, the raw captured lines, the gated lines and the non-maskable status. A fault status word always reads zero. Any other access is invalid: it raises a one-cycle error pulse, leaves all state as it was and returns zero data. The non-maskable output is asserted whenever either non-maskable line is captured high, and the mask has no effect on it.

Top module: `irqv_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the outputs are zero: `core_irq`, `core_vec`, `core_nmi`, `reg_rdata` and `reg_err`. Mask, raw and non-maskable state are all zero.
- R2: At each clock edge, input line n (1..30), carried on `irq_lines[n-1]`, is captured into raw bit n-1. A read at offset 0x04 returns the raw word with bits 31:30 at zero.
- R3: A write at offset 0x00 stores `reg_wdata[29:0]` as the mask, and a read at 0x00 returns it with bits 31:30 at zero. A read at 0x08 returns raw AND mask.
- R4: When exactly one gated bit i is set, the clock edge after the change in raw or mask drives `core_vec` = 0x31 + i and `core_irq` = 1.
- R5: When two or more gated bits are set, `core_vec` = 0x30 and `core_irq` = 1, with the same one-edge latency.
- R6: When no gated bit is set, `core_vec` = 0 and `core_irq` = 0, with the same one-edge latency.
- R7: Bit j of the word read at 0x0C is `nmi_lines[j]` as captured at the last edge. `core_nmi` is 1 whenever either captured bit is 1, whatever the mask holds.
- R8: A read at offset 0x10 is valid, returns zero and raises no error.
- R9: An access is invalid in these cases: a write to any offset other than 0x00, or a read of an unaligned offset or of an offset at or above 0x14. An invalid access pulses `reg_err` for one cycle, returns zero data and changes no state.
- R10: `reg_rdata` carries the read result in the cycle after the edge that sampled `reg_rd`, and is zero otherwise. When `reg_wr` and `reg_rd` are both high, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 30 | Maskable request levels; bit n-1 is line n |
| nmi_lines | input | 2 | Non-maskable request levels |
| reg_addr | input | 5 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| reg_err | output | 1 | One-cycle invalid-access pulse |
| core_irq | output | 1 | Interrupt request to the core |
| core_vec | output | 8 | Interrupt vector to the core |
| core_nmi | output | 1 | Non-maskable request to the core |

## Verification
Every cycle, the assertions check four things. The request wire and the vector always agree. One, several or no gated bits lead to a per-source vector, the shared vector or silence on the next edge. A non-maskable line's level shows up on `core_nmi` one edge later. An invalid access never changes the mask and always returns zero data. Some behaviours need the bench's scenarios and its reference model: the exact vector value for each bit position, how the register words line up and which bits read as zero, that a rejected write leaves the mask readable as before, and a write winning over a read in the same cycle.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  localparam int unsigned DEF_LINES  = 30;
  localparam int unsigned DEF_NMI    = 2;
  localparam int unsigned DEF_ADDR_W = 5;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_VEC_W  = 8;

  typedef enum logic [2:0] {
    SEL_MASK,
    SEL_RAW,
    SEL_GATED,
    SEL_NMI,
    SEL_FAULT,
    SEL_NONE
  } reg_sel_e;

  // Byte offset to register; word aligned, five words from zero.
  function automatic reg_sel_e decode_reg(input logic [31:0] off);
    reg_sel_e s;
    if (off[1:0] != 2'b00) begin
      s = SEL_NONE;
    end else begin
      case (off[31:2])
        30'd0:   s = SEL_MASK;
        30'd1:   s = SEL_RAW;
        30'd2:   s = SEL_GATED;
        30'd3:   s = SEL_NMI;
        30'd4:   s = SEL_FAULT;
        default: s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

  // Number of set bits in a gated word.
  function automatic int unsigned count_set(input logic [31:0] w);
    int unsigned c;
    c = 0;
    for (int i = 0; i < 32; i++) begin
      if (w[i]) c++;
    end
    return c;
  endfunction

  // Vector for a gated word: zero, shared, or base plus bit index.
  function automatic logic [7:0] vec_encode(input logic [31:0] w,
                                            input logic [7:0]  base,
                                            input logic [7:0]  shared);
    logic [7:0] v;
    v = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      if (w[i]) v = base + 8'(i);
    end
    if (count_set(w) > 1) v = shared;
    return v;
  endfunction

endpackage

// File: rtl/irqv_capture.sv
module irqv_capture #(
  parameter int unsigned W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_in,
  output logic [W-1:0] lvl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_in;
  end

endmodule

// File: rtl/irqv_encoder.sv
module irqv_encoder
  import irqv_pkg::*;
#(
  parameter int unsigned N_LINES = DEF_LINES,
  parameter int unsigned VEC_W   = DEF_VEC_W,
  parameter logic [7:0]  VEC_SHR = 8'h30,
  parameter logic [7:0]  VEC_ONE = 8'h31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] gated,
  output logic               irq_q,
  output logic [VEC_W-1:0]   vec_q
);

  localparam int unsigned PAD = 32 - N_LINES;

  logic [31:0]      gated_w;
  int unsigned      n_set;
  logic [VEC_W-1:0] vec_nxt;

  assign gated_w = {{PAD{1'b0}}, gated};
  assign n_set   = count_set(gated_w);
  assign vec_nxt = VEC_W'(vec_encode(gated_w, VEC_ONE, VEC_SHR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= (n_set != 0);
      vec_q <= vec_nxt;
    end
  end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(gated) == 1) |=> (irq_q && vec_q >= VEC_W'(VEC_ONE) && vec_q < VEC_W'(VEC_ONE) + VEC_W'(N_LINES))); // R4
  AST_SHARED_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(gated) > 1) |=> (irq_q && vec_q == VEC_W'(VEC_SHR))); // R5
  AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (gated == '0) |=> (!irq_q && vec_q == '0)); // R6
  AST_PAIR_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (vec_q != '0)); // R4

endmodule

// File: rtl/irqv_regfile.sv
module irqv_regfile
  import irqv_pkg::*;
#(
  parameter int unsigned N_LINES = DEF_LINES,
  parameter int unsigned N_NMI   = DEF_NMI,
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned DATA_W  = DEF_DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic               acc_wr,
  input  logic               acc_rd,
  input  logic [DATA_W-1:0]  acc_wdata,
  input  logic [N_LINES-1:0] raw_in,
  input  logic [N_LINES-1:0] gated_in,
  input  logic [N_NMI-1:0]   nmi_in,
  output logic [N_LINES-1:0] mask_q,
  output logic [DATA_W-1:0]  rdata_q,
  output logic               err_q
);

  reg_sel_e          sel;
  logic              wr_ok;
  logic              rd_ok;
  logic              bad_acc;
  logic [DATA_W-1:0] rd_mux;

  assign sel     = decode_reg(32'(acc_addr));
  assign wr_ok   = acc_wr && (sel == SEL_MASK);
  assign rd_ok   = acc_rd && !acc_wr && (sel != SEL_NONE);
  assign bad_acc = (acc_wr && (sel != SEL_MASK)) ||
                   (acc_rd && !acc_wr && (sel == SEL_NONE));

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_MASK:  rd_mux[N_LINES-1:0] = mask_q;
      SEL_RAW:   rd_mux[N_LINES-1:0] = raw_in;
      SEL_GATED: rd_mux[N_LINES-1:0] = gated_in;
      SEL_NMI:   rd_mux[N_NMI-1:0]   = nmi_in;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (wr_ok) mask_q <= acc_wdata[N_LINES-1:0];
      rdata_q <= rd_ok ? rd_mux : '0;
      err_q   <= bad_acc;
    end
  end

  AST_BAD_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> $stable(mask_q)); // R9
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (rdata_q == '0)); // R9
  AST_MASK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (mask_q == $past(acc_wdata[N_LINES-1:0]))); // R3
  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> (rdata_q == '0)); // R10

endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int unsigned N_LINES = DEF_LINES,
  parameter int unsigned N_NMI   = DEF_NMI,
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned VEC_W   = DEF_VEC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic [N_NMI-1:0]   nmi_lines,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_err,
  output logic               core_irq,
  output logic [VEC_W-1:0]   core_vec,
  output logic               core_nmi
);

  logic [N_LINES-1:0] raw_q;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] gated;
  logic [N_NMI-1:0]   nmi_q;

  irqv_capture #(.W(N_LINES)) u_cap_irq (
    .clk(clk), .rst_n(rst_n), .lvl_in(irq_lines), .lvl_q(raw_q));

  irqv_capture #(.W(N_NMI)) u_cap_nmi (
    .clk(clk), .rst_n(rst_n), .lvl_in(nmi_lines), .lvl_q(nmi_q));

  assign gated    = raw_q & mask_q;
  assign core_nmi = |nmi_q;

  irqv_regfile #(
    .N_LINES(N_LINES), .N_NMI(N_NMI), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .acc_addr(reg_addr), .acc_wr(reg_wr), .acc_rd(reg_rd), .acc_wdata(reg_wdata),
    .raw_in(raw_q), .gated_in(gated), .nmi_in(nmi_q),
    .mask_q(mask_q), .rdata_q(reg_rdata), .err_q(reg_err));

  irqv_encoder #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .gated(gated), .irq_q(core_irq), .vec_q(core_vec));

  AST_NMI_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|nmi_lines) |=> core_nmi); // R7
  AST_NMI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !(|nmi_lines) |=> !core_nmi); // R7
  AST_RAW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_q == $past(irq_lines))); // R2

endmodule

// File: tb/sim_irqv_ctrl.sv
`timescale 1ns/1ps
module sim_irqv_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] irq_lines = '0;
  logic [1:0]  nmi_lines = '0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        core_irq;
  logic [7:0]  core_vec;
  logic        core_nmi;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irqv_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi_lines(nmi_lines),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_err(reg_err),
    .core_irq(core_irq), .core_vec(core_vec), .core_nmi(core_nmi));

  // Reference model state
  logic [29:0] m_mask, m_raw;
  logic [1:0]  m_nmi;
  logic        e_irq, e_nmi, e_err;
  logic [7:0]  e_vec;
  logic [31:0] e_rdata;
  string       rd_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = '0; m_raw = '0; m_nmi = '0;
      e_irq = 0; e_nmi = 0; e_err = 0; e_vec = 0; e_rdata = 0;
      rd_tag = "R1";
    end else begin
      logic [29:0] g;
      logic [29:0] next_mask;
      int hits;
      int low;
      g = m_raw & m_mask;
      hits = 0; low = -1;
      for (int k = 29; k >= 0; k--) if (g[k]) begin hits++; low = k; end
      e_irq = (hits > 0);
      e_vec = (hits == 0) ? 8'h00 : (hits == 1) ? 8'(49 + low) : 8'h30;
      next_mask = m_mask;
      e_rdata = 0; e_err = 0; rd_tag = "R10";
      if (reg_wr) begin
        rd_tag = "R10";
        if (reg_addr == 5'h00) next_mask = reg_wdata[29:0];
        else begin e_err = 1; rd_tag = "R9"; end
      end else if (reg_rd) begin
        case (reg_addr)
          5'h00: begin e_rdata = {2'b00, m_mask}; rd_tag = "R3"; end
          5'h04: begin e_rdata = {2'b00, m_raw};  rd_tag = "R2"; end
          5'h08: begin e_rdata = {2'b00, g};      rd_tag = "R3"; end
          5'h0C: begin e_rdata = {30'd0, m_nmi};  rd_tag = "R7"; end
          5'h10: begin e_rdata = 0;               rd_tag = "R8"; end
          default: begin e_err = 1;               rd_tag = "R9"; end
        endcase
      end
      m_raw = irq_lines; m_nmi = nmi_lines; m_mask = next_mask;
      e_nmi = (m_nmi != 0);
    end
  end

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      string vtag;
      cycles++;
      if (!rst_n || rd_tag == "R1") vtag = "R1";
      else if (e_vec == 8'h00) vtag = "R6";
      else if (e_vec == 8'h30) vtag = "R5";
      else vtag = "R4";
      cmp(vtag, "core_irq", 32'(core_irq), 32'(e_irq));
      cmp(vtag, "core_vec", 32'(core_vec), 32'(e_vec));
      cmp((!rst_n) ? "R1" : "R7", "core_nmi", 32'(core_nmi), 32'(e_nmi));
      cmp(rd_tag, "reg_rdata", reg_rdata, e_rdata);
      cmp((!rst_n) ? "R1" : "R9", "reg_err", 32'(reg_err), 32'(e_err));
    end
  end

  task automatic tick(); @(negedge clk); #0.5; endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; reg_rd = 0;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a);
    reg_addr = a; reg_rd = 1; reg_wr = 0;
    tick();
    reg_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    // R1: reset state observed while reset is held
    idle(3);
    rst_n = 1'b1;
    idle(2);
    rd(5'h00); rd(5'h04); rd(5'h08); rd(5'h0C); rd(5'h10); // R1, R8
    // R6: lines active but mask closed
    irq_lines = 30'h5;
    idle(2);
    rd(5'h04); rd(5'h08); // R2, R3
    // R3/R5: open the whole mask, upper bits must not stick
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00); rd(5'h08);
    idle(2);
    // R4: single source at the ends of the range
    irq_lines = 30'h1; idle(2);
    irq_lines = 30'h2000_0000; idle(2);
    // R4: mask narrows a two-line pattern to bit 7
    irq_lines = 30'h88;
    wr(5'h00, 32'h80);
    idle(2);
    rd(5'h08);
    // R6: clear lines
    irq_lines = 30'h0; idle(2);
    // R7: NMI ignores the closed mask
    wr(5'h00, 32'h0);
    nmi_lines = 2'b01; idle(1); rd(5'h0C);
    nmi_lines = 2'b10; idle(1); rd(5'h0C);
    nmi_lines = 2'b11; idle(1); rd(5'h0C);
    nmi_lines = 2'b00; idle(2); rd(5'h0C);
    // R9: invalid accesses leave the mask readable as before
    wr(5'h00, 32'h0000_1234);
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h14); rd(5'h02); rd(5'h1F);
    rd(5'h00);
    // R10: write and read together, write wins
    reg_addr = 5'h00; reg_wdata = 32'h3; reg_wr = 1; reg_rd = 1;
    tick();
    reg_wr = 0; reg_rd = 0;
    rd(5'h00);
    // R4: walk every single line through the open mask
    wr(5'h00, 32'h3FFF_FFFF);
    for (int b = 0; b < 30; b++) begin
      irq_lines = 30'd1 << b;
      idle(2);
    end
    // R5: all lines together
    irq_lines = '1; idle(2);
    irq_lines = '0; idle(3);
    finish_run();
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

endmodule